// File: doc/BRIEF.md
# Module Slot Register-Space Bridge

This bridge sits between a host port and a row of plug-in module slots. Each slot exposes three small register spaces: input/output registers, identification bytes and interrupt-vector registers. The host sees a single 1 KiB window. Every host access is byte or halfword wide. The bridge splits the address into a slot number, a space code and an offset. It masks the offset to the size of the selected space and passes the access to the shared target port, which uses a valid/ready handshake. Read data returns to the host when the target answers.

An endian-mode input selects byte-lane handling for big-endian hosts. In that mode, byte accesses swap odd and even addresses, and halfword data has its two bytes exchanged in both directions. Accesses to an empty slot, or to the space code that maps to nothing, never reach the target. They complete locally: reads return zero and writes are discarded.

A host read of the interrupt space at offset 0 or 2 is also an acknowledge cycle. If the matching interrupt line of that slot is pending and configured for level mode, the bridge pulses a lower request for that line. The pulse is issued alongside the completion of the read.

Top module: `ipslot_bridge`

## Requirements
- R1: After reset, tgtValid, hostDone and every ackLower bit are low.
- R2: The slot number is taken from address bits [9:8]. The space code is taken from bits [7:6]: 0 selects I/O space, 1 selects ID space, 3 selects INT space and 2 is unused. The slot and space codes are presented unchanged on tgtSlot and tgtSpace.
- R3: For I/O space, tgtOffset carries address bits [6:0]. For ID and INT space, it carries bits [5:0], with tgtOffset[6] forced to 0.
- R4: When bigEndian is 1 and the access is a byte access, address bit 0 is inverted before decoding. For halfword accesses, and when bigEndian is 0, the address is used unchanged.
- R5: When bigEndian is 1 and the access is a halfword access, the two bytes are exchanged in both directions: tgtWdata = {reqWdata[7:0], reqWdata[15:8]}, and hostRdata is built the same way from tgtRdata. In every other case, data passes through unchanged.
- R6: An access to a slot whose slotPresent bit is 0 raises no target request. It completes with hostDone, and a read returns hostRdata = 0.
- R7: An access to space code 2 raises no target request. It completes with hostDone, and a read returns hostRdata = 0.
- R8: A read is an acknowledge when it is forwarded to the target, selects INT space and has a decoded offset of 0 or 2. It pulses ackLower[2*slot + offset/2] for one cycle, together with hostDone, but only if intPending of that bit is 1 and intEdge of that bit is 0. No other access raises any ackLower bit.
- R9: tgtValid stays high, with slot, space, offset and data unchanged, until tgtReady is seen. hostDone is a one-cycle pulse that follows the cycle in which the target accepted, or follows the local completion.
- R10: A forwarded read returns the tgtRdata value that was present in the cycle tgtReady was high, subject to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bigEndian | input | 1 | Big-endian byte-lane mode |
| slotPresent | input | 4 | One bit per slot, 1 = module fitted |
| intPending | input | 8 | Interrupt status, bit 2*slot+n for line n |
| intEdge | input | 8 | 1 = line is edge-sensitive, same indexing |
| reqValid | input | 1 | Host request, held until hostDone |
| reqWrite | input | 1 | 1 = write |
| reqWide | input | 1 | 1 = halfword, 0 = byte |
| reqAddr | input | 10 | Host byte address in the window |
| reqWdata | input | 16 | Host write data |
| hostDone | output | 1 | Completion pulse |
| hostRdata | output | 16 | Read data, valid with hostDone |
| tgtValid | output | 1 | Target request valid |
| tgtReady | input | 1 | Target accepts / answers |
| tgtSlot | output | 2 | Target slot number |
| tgtSpace | output | 2 | Target space code |
| tgtOffset | output | 7 | Masked offset within the space |
| tgtWrite | output | 1 | Target write enable |
| tgtWdata | output | 16 | Target write data |
| tgtRdata | input | 16 | Target read data, sampled with tgtReady |
| ackLower | output | 8 | One-cycle acknowledge pulse per interrupt line |

## Verification
The decode state is captured once per request. A wrong captured address, space or swap decision therefore shows up at the ports in the same access: on tgtSlot, tgtSpace and tgtOffset, or in hostRdata when hostDone is returned, at most a few cycles later. A wrong state in the handshake control appears either as a target request for an empty slot or unused space, or as a missing completion. The latter is caught by the per-access timeout. Acknowledge faults appear as an ackLower pulse that is missing or misplaced in the one cycle that carries hostDone. The sweeps cover every address, both widths and both endian modes, against changing pending and edge patterns.

// File: rtl/ipslot_pkg.sv
package ipslot_pkg;
  typedef enum logic [1:0] {
    SPC_IO   = 2'd0,
    SPC_ID   = 2'd1,
    SPC_NONE = 2'd2,
    SPC_INT  = 2'd3
  } space_e;

  typedef struct packed {
    logic capReq;   // latch a new host request
    logic capRsp;   // latch target response and ack pulse
    logic capZero;  // complete locally with zero data
  } strobe_t;
endpackage

// File: rtl/ipslot_datapath.sv
module ipslot_datapath
  import ipslot_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 16,
  parameter int OFF_W     = 7,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int ADDR_W   = 8 + SLOT_W,
  localparam int NUM_INT  = 2 * NUM_SLOTS,
  localparam int BYTES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              bigEndian,
  input  logic [NUM_SLOTS-1:0] slotPresent,
  input  logic [NUM_INT-1:0]   intPending,
  input  logic [NUM_INT-1:0]   intEdge,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] tgtRdata,
  output logic              fwdOk,
  output logic [SLOT_W-1:0] tgtSlot,
  output logic [1:0]        tgtSpace,
  output logic [OFF_W-1:0]  tgtOffset,
  output logic              tgtWrite,
  output logic [DATA_W-1:0] tgtWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [NUM_INT-1:0] ackLower
);

  function automatic logic [DATA_W-1:0] laneSwap(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BYTES; b++) begin
      r[b*8 +: 8] = v[(BYTES-1-b)*8 +: 8];
    end
    return r;
  endfunction

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic              swapQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [NUM_INT-1:0] ackQ;
  logic [NUM_INT-1:0] ackNext;
  logic [ADDR_W-1:0] addrAdj;
  logic              swapNow;

  // Byte lanes are mirrored only for byte accesses in big-endian mode.
  always_comb begin
    addrAdj    = reqAddr;
    addrAdj[0] = reqAddr[0] ^ (bigEndian & ~reqWide);
    swapNow    = bigEndian & reqWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      swapQ  <= 1'b0;
      wdataQ <= '0;
    end else if (strb.capReq) begin
      addrQ  <= addrAdj;
      writeQ <= reqWrite;
      swapQ  <= swapNow;
      wdataQ <= swapNow ? laneSwap(reqWdata) : reqWdata;
    end
  end

  always_comb begin
    tgtSlot   = addrQ[ADDR_W-1:8];
    tgtSpace  = addrQ[7:6];
    tgtOffset = (space_e'(tgtSpace) == SPC_IO) ? addrQ[OFF_W-1:0]
                                               : {1'b0, addrQ[OFF_W-2:0]};
    tgtWrite  = writeQ;
    tgtWdata  = wdataQ;
    fwdOk     = slotPresent[tgtSlot] && (space_e'(tgtSpace) != SPC_NONE);
  end

  // Acknowledge decode: one candidate per interrupt line.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar n = 0; n < 2; n++) begin : g_line
      always_comb begin
        ackNext[2*s+n] = !writeQ && fwdOk
                      && (space_e'(tgtSpace) == SPC_INT)
                      && (tgtSlot == SLOT_W'(s))
                      && (tgtOffset == OFF_W'(2*n))
                      && intPending[2*s+n] && !intEdge[2*s+n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
      ackQ   <= '0;
    end else begin
      ackQ <= strb.capRsp ? ackNext : '0;
      if (strb.capRsp) begin
        rdataQ <= swapQ ? laneSwap(tgtRdata) : tgtRdata;
      end else if (strb.capZero) begin
        rdataQ <= '0;
      end
    end
  end

  assign hostRdata = rdataQ;
  assign ackLower  = ackQ;

endmodule

// File: rtl/ipslot_ctrl.sv
module ipslot_ctrl
  import ipslot_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    fwdOk,
  input  logic    tgtReady,
  output strobe_t strb,
  output logic    tgtValid,
  output logic    hostDone
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_RESP} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    tgtValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capReq = 1'b1;
          stateNext   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (!fwdOk) begin
          strb.capZero = 1'b1;
          stateNext    = ST_RESP;
        end else begin
          tgtValid = 1'b1;
          if (tgtReady) begin
            strb.capRsp = 1'b1;
            stateNext   = ST_RESP;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hostDone = (state == ST_RESP);

endmodule

// File: rtl/ipslot_bridge.sv
module ipslot_bridge
  import ipslot_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 16,
  parameter int OFF_W     = 7,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int ADDR_W   = 8 + SLOT_W,
  localparam int NUM_INT  = 2 * NUM_SLOTS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bigEndian,
  input  logic [NUM_SLOTS-1:0] slotPresent,
  input  logic [NUM_INT-1:0]   intPending,
  input  logic [NUM_INT-1:0]   intEdge,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqWide,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 hostDone,
  output logic [DATA_W-1:0]    hostRdata,
  output logic                 tgtValid,
  input  logic                 tgtReady,
  output logic [SLOT_W-1:0]    tgtSlot,
  output logic [1:0]           tgtSpace,
  output logic [OFF_W-1:0]     tgtOffset,
  output logic                 tgtWrite,
  output logic [DATA_W-1:0]    tgtWdata,
  input  logic [DATA_W-1:0]    tgtRdata,
  output logic [NUM_INT-1:0]   ackLower
);

  strobe_t strb;
  logic    fwdOk;

  ipslot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .fwdOk    (fwdOk),
    .tgtReady (tgtReady),
    .strb     (strb),
    .tgtValid (tgtValid),
    .hostDone (hostDone)
  );

  ipslot_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .OFF_W     (OFF_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .bigEndian   (bigEndian),
    .slotPresent (slotPresent),
    .intPending  (intPending),
    .intEdge     (intEdge),
    .reqWrite    (reqWrite),
    .reqWide     (reqWide),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .tgtRdata    (tgtRdata),
    .fwdOk       (fwdOk),
    .tgtSlot     (tgtSlot),
    .tgtSpace    (tgtSpace),
    .tgtOffset   (tgtOffset),
    .tgtWrite    (tgtWrite),
    .tgtWdata    (tgtWdata),
    .hostRdata   (hostRdata),
    .ackLower    (ackLower)
  );

endmodule

// File: rtl/ipslot_bridge_chk.sv
module ipslot_bridge_chk #(
  parameter int SLOT_W  = 2,
  parameter int OFF_W   = 7,
  parameter int DATA_W  = 16,
  parameter int NUM_INT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               tgtValid,
  input logic               tgtReady,
  input logic [SLOT_W-1:0]  tgtSlot,
  input logic [1:0]         tgtSpace,
  input logic [OFF_W-1:0]   tgtOffset,
  input logic [DATA_W-1:0]  tgtWdata,
  input logic               hostDone,
  input logic [NUM_INT-1:0] ackLower
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid && !tgtReady |=> tgtValid && $stable(tgtSlot) && $stable(tgtSpace)
                              && $stable(tgtOffset) && $stable(tgtWdata));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  p_no_unused_r7: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> tgtSpace != 2'd2);

  p_short_offset_r3: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid && tgtSpace != 2'd0 |-> !tgtOffset[OFF_W-1]);

  p_ack_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|ackLower) |-> hostDone && $countones(ackLower) == 1);

  p_no_req_while_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |-> !tgtValid);

endmodule

bind ipslot_bridge ipslot_bridge_chk #(
  .SLOT_W  (SLOT_W),
  .OFF_W   (OFF_W),
  .DATA_W  (DATA_W),
  .NUM_INT (NUM_INT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tgtValid  (tgtValid),
  .tgtReady  (tgtReady),
  .tgtSlot   (tgtSlot),
  .tgtSpace  (tgtSpace),
  .tgtOffset (tgtOffset),
  .tgtWdata  (tgtWdata),
  .hostDone  (hostDone),
  .ackLower  (ackLower)
);

// File: tb/sim_ipslot_bridge.sv
`timescale 1ns/1ps
module sim_ipslot_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigEndian = 1'b0;
  logic [3:0]  slotPresent = 4'b1011;
  logic [7:0]  intPending = '0;
  logic [7:0]  intEdge = '0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqWide = 1'b0;
  logic [9:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        hostDone;
  logic [15:0] hostRdata;
  logic        tgtValid;
  logic        tgtReady = 1'b0;
  logic [1:0]  tgtSlot;
  logic [1:0]  tgtSpace;
  logic [6:0]  tgtOffset;
  logic        tgtWrite;
  logic [15:0] tgtWdata;
  logic [15:0] tgtRdata = '0;
  logic [7:0]  ackLower;

  int vecCount = 0;
  int failCount = 0;
  int reqCount = 0;
  int tgtDelay = 0;
  int waitCnt = 0;
  logic [1:0]  lastSlot, lastSpace;
  logic [6:0]  lastOff;
  logic        lastWrite;
  logic [15:0] lastWdata;

  always #2.5 clk = ~clk;

  ipslot_bridge u0 (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .slotPresent(slotPresent),
    .intPending(intPending), .intEdge(intEdge), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .hostDone(hostDone), .hostRdata(hostRdata),
    .tgtValid(tgtValid), .tgtReady(tgtReady), .tgtSlot(tgtSlot),
    .tgtSpace(tgtSpace), .tgtOffset(tgtOffset), .tgtWrite(tgtWrite),
    .tgtWdata(tgtWdata), .tgtRdata(tgtRdata), .ackLower(ackLower)
  );

  function automatic logic [15:0] model(input logic [1:0] s, input logic [1:0] sp,
                                        input logic [6:0] o);
    return {4'h5, s, sp, 1'b0, o};
  endfunction

  // Target model: answers after tgtDelay cycles, records what it saw.
  always @(negedge clk) begin
    if (tgtValid && !tgtReady) begin
      if (waitCnt >= tgtDelay) begin
        tgtReady  = 1'b1;
        tgtRdata  = model(tgtSlot, tgtSpace, tgtOffset);
        lastSlot  = tgtSlot;
        lastSpace = tgtSpace;
        lastOff   = tgtOffset;
        lastWrite = tgtWrite;
        lastWdata = tgtWdata;
        reqCount++;
      end else begin
        waitCnt++;
      end
    end else begin
      tgtReady = 1'b0;
      waitCnt  = 0;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doTx(input logic w, input logic wide, input logic [9:0] a,
                      input logic [15:0] wd, input logic be);
    logic [9:0]  adj;
    logic [1:0]  s, sp;
    logic [6:0]  off;
    logic        fwd;
    logic [15:0] expR, expW;
    logic [7:0]  expAck;
    int          prev, n;
    string       tagA;
    adj    = a;
    adj[0] = a[0] ^ (be & ~wide);
    s      = adj[9:8];
    sp     = adj[7:6];
    off    = (sp == 2'd0) ? adj[6:0] : {1'b0, adj[5:0]};
    fwd    = slotPresent[s] && (sp != 2'd2);
    expR   = fwd ? model(s, sp, off) : 16'h0;
    if (be && wide) expR = {expR[7:0], expR[15:8]};
    expW   = (be && wide) ? {wd[7:0], wd[15:8]} : wd;
    expAck = '0;
    if (!w && fwd && sp == 2'd3 && (off == 7'd0 || off == 7'd2)) begin
      if (intPending[2*s + off[1]] && !intEdge[2*s + off[1]])
        expAck[2*s + off[1]] = 1'b1;
    end
    tagA = (be && !wide) ? "R4" : "R3";
    prev = reqCount;
    tgtDelay = a % 3;
    bigEndian = be; reqWrite = w; reqWide = wide; reqAddr = a; reqWdata = wd;
    reqValid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!hostDone && n < 40);
    reqValid = 1'b0;
    check("R9", "completion", {31'b0, hostDone}, 32'd1);
    check("R8", "ackLower", {24'b0, ackLower}, {24'b0, expAck});
    if (!w) begin
      if (!slotPresent[s]) check("R6", "empty rdata", {16'b0, hostRdata}, {16'b0, expR});
      else if (sp == 2'd2) check("R7", "unused rdata", {16'b0, hostRdata}, {16'b0, expR});
      else if (be && wide) check("R5", "swapped rdata", {16'b0, hostRdata}, {16'b0, expR});
      else check("R10", "rdata", {16'b0, hostRdata}, {16'b0, expR});
    end
    if (fwd) begin
      check("R2", "target count", reqCount, prev + 1);
      check("R2", "slot/space", {28'b0, lastSlot, lastSpace}, {28'b0, s, sp});
      check(tagA, "offset", {25'b0, lastOff}, {25'b0, off});
      check("R2", "write flag", {31'b0, lastWrite}, {31'b0, w});
      if (w) check("R5", "wdata", {16'b0, lastWdata}, {16'b0, expW});
    end else begin
      check(slotPresent[s] ? "R7" : "R6", "no target request", reqCount, prev);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "tgtValid at reset", {31'b0, tgtValid}, 32'd0);
    check("R1", "hostDone at reset", {31'b0, hostDone}, 32'd0);
    check("R1", "ackLower at reset", {24'b0, ackLower}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {31'b0, tgtValid}, 32'd0);
    // Read sweep: every address, both widths, both endian modes (R2..R8, R10).
    for (int be = 0; be < 2; be++) begin
      for (int wide = 0; wide < 2; wide++) begin
        for (int a = 0; a < 1024; a += (wide ? 2 : 1)) begin
          intPending = 8'(a * 37 + be);
          intEdge    = 8'(a * 11 + wide * 3);
          doTx(1'b0, wide[0], 10'(a), 16'h0, be[0]);
        end
      end
    end
    // Write sweep with distinct data patterns (R5, R6, R7).
    for (int be = 0; be < 2; be++) begin
      for (int wide = 0; wide < 2; wide++) begin
        for (int a = 0; a < 1024; a += 5) begin
          intPending = 8'hFF;
          intEdge    = 8'h00;
          doTx(1'b1, wide[0], 10'(a), 16'(a * 1237 + 16'h1A2B), be[0]);
        end
      end
    end
    // Directed R8: level, pending reads at INT offsets 0 and 2 of every slot.
    slotPresent = 4'b1111;
    for (int s = 0; s < 4; s++) begin
      for (int ln = 0; ln < 2; ln++) begin
        intPending = 8'hFF; intEdge = 8'h00;
        doTx(1'b0, 1'b0, 10'(s * 256 + 192 + ln * 2), 16'h0, 1'b0);
        intEdge = 8'hFF;
        doTx(1'b0, 1'b0, 10'(s * 256 + 192 + ln * 2), 16'h0, 1'b0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule